// File: doc/BRIEF.md
# Multi-term sum-of-products unit

This unit forms `z = a*b + c*d + e + f` for unsigned operands of `N` bits, in one arithmetic structure. Each product builds its own rows from an AND array, and row j is the multiplicand gated by multiplier bit j and moved left by j places. The two plain addends join the product rows as unshifted rows. A single carry-save tree of 3:2 compressors folds all `2N+2` rows down to two vectors, and one carry-propagate adder forms the result. The design does not chain separate multipliers through separate adders.

The datapath is purely combinational. The result holds the largest possible sum without overflow. A stream wrapper with no storage surrounds it. A transfer happens when `in_valid_i` and `in_ready_o` are both high. Back-pressure passes straight through, so `in_ready_o` equals `out_ready_i` and `out_valid_o` equals `in_valid_i` in the same cycle. The source must hold its operands steady while it waits for ready. The parameter `CPA_STYLE` selects the final adder: 0 gives an inferred adder and 1 gives an explicit ripple chain.

Top module: `sop_sum_of_products`

## Requirements
- R1: `z_o` equals a*b + c*d + e + f exactly for every unsigned input combination, with `z_o` being 2N+2 bits wide.
- R2: `z_o` never exceeds 2*(2^N-1)*2^N, so its top bit (bit 2N+1) is always 0.
- R3: When both multipliers b and d are zero, `z_o` equals e + f.
- R4: When c*d contributes nothing and e and f are zero, `z_o` equals a*b.
- R5: Swapping a with b and c with d leaves `z_o` unchanged.
- R6: The reduction tree yields exactly two vectors whose sum modulo 2^(2N+2) equals `z_o`.
- R7: `out_valid_o` equals `in_valid_i` and `in_ready_o` equals `out_ready_i` in every cycle, with no storage between them.
- R8: The result has zero latency: `z_o` reflects new operands without waiting for any clock edge.
- R9: Both final-adder variants (`CPA_STYLE` 0 and 1) give identical `z_o` for identical operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid_i | input | 1 | Operand set is valid |
| in_ready_o | output | 1 | Unit can accept operands (mirrors out_ready_i) |
| a_i | input | N | Multiplicand of first product |
| b_i | input | N | Multiplier of first product |
| c_i | input | N | Multiplicand of second product |
| d_i | input | N | Multiplier of second product |
| e_i | input | N | First plain addend |
| f_i | input | N | Second plain addend |
| out_valid_o | output | 1 | Result is valid (mirrors in_valid_i) |
| out_ready_i | input | 1 | Consumer accepts the result |
| z_o | output | 2N+2 | Sum-of-products result |

## Verification
The bench targets all-ones operands, where every column of the tree is full. A tree that drops a carry out of a compressor, or truncates a carry row too early, gives a wrong value there. Zero multipliers must leave only e+f. A row that is built from the wrong multiplier bit, or shifted by the wrong amount, breaks either that case or the single-product case. Swapping the operands catches rows that depend on which side of a product an operand sits. The comparison of the exhaustive 4-bit sweep with the 8-bit random run, and of the two adder styles against each other, exposes a bad carry chain in the ripple variant.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Result width: 2N+1 bits hold the maximum sum; one spare bit of headroom.
  function automatic int sop_width(input int n);
    return 2 * n + 2;
  endfunction

  // Rows entering the tree: N per product, one per plain addend.
  function automatic int sop_rows(input int n);
    return 2 * n + 2;
  endfunction

  // Rows left after one level of 3:2 compression.
  function automatic int csa_next(input int rows);
    return 2 * (rows / 3) + (rows % 3);
  endfunction

endpackage

// File: rtl/sop_ppgen.sv
module sop_ppgen #(
  parameter int N = 8,
  parameter int W = 18
) (
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  output logic [W-1:0] rows_o [N]
);

  // Row j: multiplicand gated by multiplier bit j, placed at weight 2^j.
  for (genvar j = 0; j < N; j++) begin : g_row
    logic [N-1:0] gated;
    assign gated     = mcand_i & {N{mplier_i[j]}};
    assign rows_o[j] = W'(gated) << j;
  end

endmodule

// File: rtl/sop_csa3.sv
module sop_csa3 #(
  parameter int W = 18
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);

  logic [W-2:0] maj;

  assign s_o = x_i ^ y_i ^ z_i;
  // Carry from the top column falls outside the result range and is dropped.
  assign maj = (x_i[W-2:0] & y_i[W-2:0]) |
               (x_i[W-2:0] & z_i[W-2:0]) |
               (y_i[W-2:0] & z_i[W-2:0]);
  assign c_o = {maj, 1'b0};

endmodule

// File: rtl/sop_csa_tree.sv
module sop_csa_tree #(
  parameter int W    = 18,
  parameter int ROWS = 18
) (
  input  logic [W-1:0] rows_i [ROWS],
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  localparam int GROUPS = ROWS / 3;
  localparam int LEFT   = ROWS % 3;
  localparam int NEXT   = sop_pkg::csa_next(ROWS);

  if (ROWS == 1) begin : g_one
    assign sum_o   = rows_i[0];
    assign carry_o = '0;
  end else if (ROWS == 2) begin : g_two
    assign sum_o   = rows_i[0];
    assign carry_o = rows_i[1];
  end else begin : g_level
    logic [W-1:0] nxt [NEXT];

    for (genvar g = 0; g < GROUPS; g++) begin : g_csa
      sop_csa3 #(.W(W)) u_csa (
        .x_i (rows_i[3*g]),
        .y_i (rows_i[3*g+1]),
        .z_i (rows_i[3*g+2]),
        .s_o (nxt[2*g]),
        .c_o (nxt[2*g+1])
      );
    end

    for (genvar r = 0; r < LEFT; r++) begin : g_pass
      assign nxt[2*GROUPS+r] = rows_i[3*GROUPS+r];
    end

    sop_csa_tree #(.W(W), .ROWS(NEXT)) u_next (
      .rows_i  (nxt),
      .sum_o   (sum_o),
      .carry_o (carry_o)
    );
  end

endmodule

// File: rtl/sop_cpa.sv
module sop_cpa #(
  parameter int W     = 18,
  parameter int STYLE = 0
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);

  if (STYLE == 0) begin : g_inferred
    assign sum_o = x_i + y_i;
  end else begin : g_ripple
    logic [W-1:0] cy;
    assign cy[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum_o[i] = x_i[i] ^ y_i[i] ^ cy[i];
      if (i < W - 1) begin : g_cy
        assign cy[i+1] = (x_i[i] & y_i[i]) | (x_i[i] & cy[i]) | (y_i[i] & cy[i]);
      end
    end
  end

endmodule

// File: rtl/sop_sum_of_products.sv
module sop_sum_of_products #(
  parameter  int N         = 8,
  parameter  int CPA_STYLE = 0,
  localparam int W         = sop_pkg::sop_width(N),
  localparam int ROWS      = sop_pkg::sop_rows(N)
) (
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  input  logic [N-1:0] d_i,
  input  logic [N-1:0] e_i,
  input  logic [N-1:0] f_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] z_o
);

  logic [W-1:0] ab_rows [N];
  logic [W-1:0] cd_rows [N];
  logic [W-1:0] pp_rows [ROWS];
  logic [W-1:0] csa_sum;
  logic [W-1:0] csa_carry;

  // Stream pass-through: no storage, back-pressure forwarded.
  assign out_valid_o = in_valid_i;
  assign in_ready_o  = out_ready_i;

  sop_ppgen #(.N(N), .W(W)) u_pp_ab (
    .mcand_i  (a_i),
    .mplier_i (b_i),
    .rows_o   (ab_rows)
  );

  sop_ppgen #(.N(N), .W(W)) u_pp_cd (
    .mcand_i  (c_i),
    .mplier_i (d_i),
    .rows_o   (cd_rows)
  );

  for (genvar j = 0; j < N; j++) begin : g_merge
    assign pp_rows[j]   = ab_rows[j];
    assign pp_rows[N+j] = cd_rows[j];
  end
  assign pp_rows[2*N]   = W'(e_i);
  assign pp_rows[2*N+1] = W'(f_i);

  sop_csa_tree #(.W(W), .ROWS(ROWS)) u_tree (
    .rows_i  (pp_rows),
    .sum_o   (csa_sum),
    .carry_o (csa_carry)
  );

  sop_cpa #(.W(W), .STYLE(CPA_STYLE)) u_cpa (
    .x_i   (csa_sum),
    .y_i   (csa_carry),
    .sum_o (z_o)
  );

endmodule

// File: rtl/sop_sum_of_products_chk.sv
module sop_sum_of_products_chk #(
  parameter int N = 8,
  parameter int W = 18
) (
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic [N-1:0] c_i,
  input logic [N-1:0] d_i,
  input logic [N-1:0] e_i,
  input logic [N-1:0] f_i,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic [W-1:0] z_o,
  input logic [W-1:0] tree_sum,
  input logic [W-1:0] tree_carry
);

  localparam logic [W-1:0] OPMAX = (W'(1) << N) - W'(1);
  localparam logic [W-1:0] BOUND = W'(2) * OPMAX * (W'(1) << N);

  always_comb begin
    assert_handshake_R7: assert (out_valid_o == in_valid_i && in_ready_o == out_ready_i)
      else $error("R7 handshake not forwarded");
    assert_no_overflow_R2: assert (z_o <= BOUND && z_o[W-1] == 1'b0)
      else $error("R2 result above bound");
    assert_two_vectors_R6: assert (W'(tree_sum + tree_carry) == z_o)
      else $error("R6 tree vectors disagree with result");
    if (b_i == '0 && d_i == '0) begin
      assert_addends_only_R3: assert (z_o == W'(e_i) + W'(f_i))
        else $error("R3 products not removed");
    end
    if ((c_i == '0 || d_i == '0) && e_i == '0 && f_i == '0) begin
      assert_single_product_R4: assert (z_o == W'(a_i) * W'(b_i))
        else $error("R4 single product wrong");
    end
  end

endmodule

bind sop_sum_of_products sop_sum_of_products_chk #(.N(N), .W(W)) u_chk (
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .a_i         (a_i),
  .b_i         (b_i),
  .c_i         (c_i),
  .d_i         (d_i),
  .e_i         (e_i),
  .f_i         (f_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .z_o         (z_o),
  .tree_sum    (csa_sum),
  .tree_carry  (csa_carry)
);

// File: tb/tb_sop_sum_of_products.sv
module tb_sop_sum_of_products;

  localparam int N8 = 8;
  localparam int W8 = 2 * N8 + 2;
  localparam int N4 = 4;
  localparam int W4 = 2 * N4 + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic          vin, rdy;
  logic [N8-1:0] a, b, c, d, e, f;
  logic [N4-1:0] a4, b4, c4, d4, e4, f4;
  logic          in_rdy, out_vld, in_rdy_r, out_vld_r, in_rdy4, out_vld4;
  logic [W8-1:0] z, z_rip;
  logic [W4-1:0] z4;

  sop_sum_of_products #(.N(N8), .CPA_STYLE(0)) dut (
    .in_valid_i(vin), .in_ready_o(in_rdy), .a_i(a), .b_i(b), .c_i(c), .d_i(d),
    .e_i(e), .f_i(f), .out_valid_o(out_vld), .out_ready_i(rdy), .z_o(z));

  sop_sum_of_products #(.N(N8), .CPA_STYLE(1)) dut_ripple (
    .in_valid_i(vin), .in_ready_o(in_rdy_r), .a_i(a), .b_i(b), .c_i(c), .d_i(d),
    .e_i(e), .f_i(f), .out_valid_o(out_vld_r), .out_ready_i(rdy), .z_o(z_rip));

  sop_sum_of_products #(.N(N4), .CPA_STYLE(1)) dut_n4 (
    .in_valid_i(vin), .in_ready_o(in_rdy4), .a_i(a4), .b_i(b4), .c_i(c4), .d_i(d4),
    .e_i(e4), .f_i(f4), .out_valid_o(out_vld4), .out_ready_i(rdy), .z_o(z4));

  function automatic longint expect_sop(longint x1, longint y1, longint x2, longint y2,
                                        longint p, longint q);
    return x1 * y1 + x2 * y2 + p + q;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive8(input logic [N8-1:0] xa, xb, xc, xd, xe, xf);
    a = xa; b = xb; c = xc; d = xd; e = xe; f = xf;
    #1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    vin = 1'b0; rdy = 1'b0;
    a = '0; b = '0; c = '0; d = '0; e = '0; f = '0;
    a4 = '0; b4 = '0; c4 = '0; d4 = '0; e4 = '0; f4 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #2;

    // Reset-time state: zero operands give zero result (R1), handshake idle (R7)
    check("R1 zero operands", longint'(z), 0);
    check("R7 idle valid", longint'(out_vld), 0);

    // R7: all four valid/ready combinations
    for (int k = 0; k < 4; k++) begin
      vin = k[0]; rdy = k[1];
      #1;
      check("R7 out_valid", longint'(out_vld), longint'(k[0]));
      check("R7 in_ready", longint'(in_rdy), longint'(k[1]));
    end
    vin = 1'b1; rdy = 1'b1;

    // R2 / R1: all-ones operands, every column full
    drive8('1, '1, '1, '1, '1, '1);
    check("R1 all ones", longint'(z), 130560);
    check("R2 top bit clear", longint'(z[W8-1]), 0);
    check("R9 all ones ripple", longint'(z_rip), 130560);
    a4 = '1; b4 = '1; c4 = '1; d4 = '1; e4 = '1; f4 = '1;
    #1;
    check("R2 n4 all ones", longint'(z4), 480);

    // R8: operands change with no clock edge in between
    drive8(8'd3, 8'd5, 8'd0, 8'd0, 8'd0, 8'd0);
    check("R8 first", longint'(z), 15);
    drive8(8'd7, 8'd9, 8'd0, 8'd0, 8'd0, 8'd1);
    check("R8 second", longint'(z), 64);

    // R3: multipliers zero leave the addends
    for (int k = 0; k < 50; k++) begin
      logic [N8-1:0] ra, rc, re, rf;
      ra = N8'($urandom); rc = N8'($urandom); re = N8'($urandom); rf = N8'($urandom);
      drive8(ra, '0, rc, '0, re, rf);
      check("R3 addends only", longint'(z), longint'(re) + longint'(rf));
    end

    // R4: single product, including top multiplier bit alone
    drive8(8'hFF, 8'h80, 8'h55, 8'h00, 8'h00, 8'h00);
    check("R4 top bit row", longint'(z), 255 * 128);
    drive8(8'h01, 8'hFF, 8'h00, 8'hAA, 8'h00, 8'h00);
    check("R4 unit multiplicand", longint'(z), 255);

    // R5: operand swap within each product
    for (int k = 0; k < 50; k++) begin
      logic [N8-1:0] ra, rb, rc, rd, re, rf;
      longint first;
      ra = N8'($urandom); rb = N8'($urandom); rc = N8'($urandom);
      rd = N8'($urandom); re = N8'($urandom); rf = N8'($urandom);
      drive8(ra, rb, rc, rd, re, rf);
      first = longint'(z);
      drive8(rb, ra, rd, rc, re, rf);
      check("R5 swapped", longint'(z), first);
    end

    // R1: exhaustive over the 4-bit products, random addends
    for (int v = 0; v < 65536; v++) begin
      a4 = v[3:0]; b4 = v[7:4]; c4 = v[11:8]; d4 = v[15:12];
      e4 = N4'($urandom); f4 = N4'($urandom);
      #1;
      check("R1 n4 sweep", longint'(z4),
            expect_sop(longint'(a4), longint'(b4), longint'(c4), longint'(d4),
                       longint'(e4), longint'(f4)));
    end

    // R1 / R9: random 8-bit vectors on both adder styles
    for (int k = 0; k < 20000; k++) begin
      logic [N8-1:0] ra, rb, rc, rd, re, rf;
      ra = N8'($urandom); rb = N8'($urandom); rc = N8'($urandom);
      rd = N8'($urandom); re = N8'($urandom); rf = N8'($urandom);
      drive8(ra, rb, rc, rd, re, rf);
      check("R1 n8 random", longint'(z),
            expect_sop(longint'(ra), longint'(rb), longint'(rc), longint'(rd),
                       longint'(re), longint'(rf)));
      check("R9 ripple agrees", longint'(z_rip), longint'(z));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule